// File: doc/BRIEF.md
# Linked-Descriptor Receive DMA Engine

This block takes received frames as a byte stream and stores them in memory buffers. Software describes the buffers with a linked list of descriptors in a word-addressed RAM. Each descriptor is four 32-bit words: word 0 holds the link to the next descriptor, word 1 is the command/status word, word 2 holds the buffer's word address, and word 3 belongs to software. Software hands a descriptor to the engine by clearing bit 31 of its status word and putting the buffer size in bytes into bits 11:0.

The engine reads the status word, the buffer pointer and the link of a descriptor, then packs incoming bytes into the buffer. When the frame or the buffer ends, it writes the status word back with bit 31 set, and then moves on along the link. If a frame does not fit in one buffer, the rest of it goes into the next descriptor. The engine parks when it reaches a descriptor it does not own. While parked it discards arriving bytes and records an overrun. A new enable command makes it try again, either at the descriptor it stopped on or at a newly loaded ring base.

Top module: `rx_ring_dma`

## Requirements
- R1: The engine uses a descriptor only when bit 31 of its status word reads 0. When bit 31 reads 1, the engine goes idle and issues no further memory requests.
- R2: Byte n of a frame segment is stored at word address buffer + n/4, in bits 8*(n mod 4)+7 down to 8*(n mod 4) (little-endian lanes).
- R3: A partly filled last word is written with byte enables covering only its received bytes. Other bytes of that word keep their old contents.
- R4: Write-back sets bit 31 and puts the segment's byte count, trailing CRC bytes included, into bits 11:0. Bit 27 (packet OK) is set only when the segment ends the frame and no error or overrun applies.
- R5: Bit 29 (interrupt request) in the written-back word copies bit 29 of the word software handed over.
- R6: A frame longer than the buffer fills the buffer exactly. That write-back has bit 30 (more) set, bit 27 clear and a count equal to the buffer size, and the frame continues at byte 0 of the next descriptor's buffer.
- R7: An error flag given with the last byte sets bit 19 (CRC error) and clears bit 27.
- R8: After each write-back the engine follows the descriptor's link word, so a list closed into a ring wraps from the last entry back to the first.
- R9: Bytes offered while the engine is idle are accepted and discarded. The next write-back then sets bit 25 (overrun) and clears bit 27, and the write-back after that no longer carries bit 25.
- R10: An enable with the base-load input low resumes at the descriptor where the engine stopped. An enable with base-load high starts at ring_base.
- R11: rx_ready is low while a descriptor is being read or written back, and high while idle or receiving.
- R12: After reset the engine is idle: rx_ready is high and no memory request is issued.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_enable | input | 1 | Start command pulse; acted on only while idle |
| base_load | input | 1 | With rx_enable, restart at ring_base |
| ring_base | input | AW | Word address of the first descriptor |
| rx_valid | input | 1 | Stream byte valid |
| rx_data | input | 8 | Stream byte |
| rx_last | input | 1 | Byte is the last of its frame |
| rx_err | input | 1 | Frame error, sampled with the last byte |
| rx_ready | output | 1 | Byte is taken this cycle when rx_valid is high |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | AW | Word address |
| mem_wdata | output | 32 | Write data |
| mem_be | output | 4 | Byte enables for writes |
| mem_rdata | input | 32 | Read data, valid one cycle after the read request |

## Verification
Most wrong internal states reach memory within a single frame.

- A wrong byte count or lane pointer puts data at the wrong word or lane, or leaves a partial word's neighbouring bytes damaged, and this shows up in the buffer words as soon as the segment is written back.
- A wrong ownership or link state makes the engine overwrite a descriptor software still holds, or skip one that is free. The status words show this by the next write-back.
- A lost overrun flag can only be seen on the first write-back after the engine restarts from idle, so each idle-then-restart sequence needs its own check.

// File: rtl/rxd_pkg.sv
package rxd_pkg;

  localparam int WORD_BITS = 32;
  localparam int LANES     = WORD_BITS / 8;
  localparam int SZW       = 12;

  // descriptor word offsets (behavioural: fixed descriptor layout)
  localparam int OFS_LINK = 0;
  localparam int OFS_STAT = 1;
  localparam int OFS_BUF  = 2;

  // status word bit positions
  localparam int B_OWN  = 31;
  localparam int B_MORE = 30;
  localparam int B_INTR = 29;
  localparam int B_OK   = 27;
  localparam int B_OVR  = 25;
  localparam int B_CRC  = 19;

  typedef enum logic [2:0] {
    S_IDLE, S_RD_STAT, S_RD_BUF, S_RD_LINK, S_ARM, S_RECV, S_WB
  } rxd_state_t;

  function automatic logic [WORD_BITS-1:0] make_status(
    input logic           more,
    input logic           intr,
    input logic           crc_bad,
    input logic           ovr,
    input logic [SZW-1:0] count
  );
    logic [WORD_BITS-1:0] w;
    w            = '0;
    w[B_OWN]     = 1'b1;
    w[B_MORE]    = more;
    w[B_INTR]    = intr;
    w[B_OK]      = !more && !crc_bad && !ovr;
    w[B_OVR]     = ovr;
    w[B_CRC]     = crc_bad;
    w[SZW-1:0]   = count;
    return w;
  endfunction

endpackage

// File: rtl/rxd_lane_pack.sv
module rxd_lane_pack #(
  parameter int LANES = 4,
  localparam int LW = $clog2(LANES)
) (
  input  logic [8*LANES-1:0] acc_i,
  input  logic [LANES-1:0]   be_i,
  input  logic [7:0]         byte_i,
  input  logic [LW-1:0]      lane_i,
  output logic [8*LANES-1:0] word_o,
  output logic [LANES-1:0]   be_o
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic hit;
    assign hit              = (lane_i == LW'(g));
    assign word_o[8*g +: 8] = hit ? byte_i : acc_i[8*g +: 8];
    assign be_o[g]          = be_i[g] | hit;
  end
endmodule

// File: rtl/rxd_wb_fmt.sv
module rxd_wb_fmt
  import rxd_pkg::*;
(
  input  logic                 more_i,
  input  logic                 intr_i,
  input  logic                 crc_i,
  input  logic                 ovr_i,
  input  logic [SZW-1:0]       count_i,
  output logic [WORD_BITS-1:0] status_o
);
  assign status_o = make_status(more_i, intr_i, crc_i, ovr_i, count_i);
endmodule

// File: rtl/rx_ring_dma.sv
module rx_ring_dma
  import rxd_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rx_enable,
  input  logic                 base_load,
  input  logic [AW-1:0]        ring_base,
  input  logic                 rx_valid,
  input  logic [7:0]           rx_data,
  input  logic                 rx_last,
  input  logic                 rx_err,
  output logic                 rx_ready,
  output logic                 mem_req,
  output logic                 mem_we,
  output logic [AW-1:0]        mem_addr,
  output logic [WORD_BITS-1:0] mem_wdata,
  output logic [LANES-1:0]     mem_be,
  input  logic [WORD_BITS-1:0] mem_rdata
);
  localparam int LW = $clog2(LANES);

  rxd_state_t           st;
  logic [AW-1:0]        desc_ptr, link_q, bufp;
  logic [SZW-1:0]       size_q, cnt;
  logic                 intr_q, more_q, crc_q, ovr_pend;
  logic [WORD_BITS-1:0] acc;
  logic [LANES-1:0]     be_acc;

  // named internal events
  logic                 acc_byte, drop_byte, buf_full, seg_end, flush;
  logic                 wb_fire, own_stop, fetching;
  logic [SZW-1:0]       cnt_next;
  logic [LW-1:0]        lane;
  logic [WORD_BITS-1:0] merged_word, status_word;
  logic [LANES-1:0]     merged_be;

  assign cnt_next  = cnt + SZW'(1);
  assign lane      = cnt[LW-1:0];
  assign acc_byte  = (st == S_RECV) && rx_valid;
  assign drop_byte = (st == S_IDLE) && rx_valid;
  assign buf_full  = (cnt_next == size_q);
  assign seg_end   = acc_byte && (rx_last || buf_full);
  assign flush     = acc_byte && (lane == LW'(LANES - 1) || rx_last || buf_full);
  assign wb_fire   = (st == S_WB);
  assign own_stop  = (st == S_RD_BUF) && mem_rdata[B_OWN];
  assign fetching  = (st == S_RD_STAT) || (st == S_RD_BUF) ||
                     (st == S_RD_LINK) || (st == S_ARM) || (st == S_WB);
  assign rx_ready  = (st == S_IDLE) || (st == S_RECV);

  rxd_lane_pack #(.LANES(LANES)) u_pack (
    .acc_i  (acc),
    .be_i   (be_acc),
    .byte_i (rx_data),
    .lane_i (lane),
    .word_o (merged_word),
    .be_o   (merged_be)
  );

  rxd_wb_fmt u_fmt (
    .more_i   (more_q),
    .intr_i   (intr_q),
    .crc_i    (crc_q),
    .ovr_i    (ovr_pend),
    .count_i  (cnt),
    .status_o (status_word)
  );

  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = desc_ptr;
    mem_wdata = '0;
    mem_be    = '0;
    unique case (st)
      S_RD_STAT: begin
        mem_req  = 1'b1;
        mem_addr = desc_ptr + AW'(OFS_STAT);
      end
      S_RD_BUF: begin
        mem_req  = !mem_rdata[B_OWN];
        mem_addr = desc_ptr + AW'(OFS_BUF);
      end
      S_RD_LINK: begin
        mem_req  = 1'b1;
        mem_addr = desc_ptr + AW'(OFS_LINK);
      end
      S_RECV: begin
        if (flush) begin
          mem_req   = 1'b1;
          mem_we    = 1'b1;
          mem_addr  = bufp + AW'(cnt[SZW-1:LW]);
          mem_wdata = merged_word;
          mem_be    = merged_be;
        end
      end
      S_WB: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = desc_ptr + AW'(OFS_STAT);
        mem_wdata = status_word;
        mem_be    = '1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      desc_ptr <= '0;
      link_q   <= '0;
      bufp     <= '0;
      size_q   <= '0;
      cnt      <= '0;
      intr_q   <= 1'b0;
      more_q   <= 1'b0;
      crc_q    <= 1'b0;
      acc      <= '0;
      be_acc   <= '0;
    end else begin
      unique case (st)
        S_IDLE: begin
          if (rx_enable) begin
            if (base_load) desc_ptr <= ring_base;
            st <= S_RD_STAT;
          end
        end
        S_RD_STAT: st <= S_RD_BUF;
        S_RD_BUF: begin
          if (mem_rdata[B_OWN]) begin
            st <= S_IDLE;
          end else begin
            size_q <= mem_rdata[SZW-1:0];
            intr_q <= mem_rdata[B_INTR];
            st     <= S_RD_LINK;
          end
        end
        S_RD_LINK: begin
          bufp <= mem_rdata[AW-1:0];
          st   <= S_ARM;
        end
        S_ARM: begin
          link_q <= mem_rdata[AW-1:0];
          cnt    <= '0;
          acc    <= '0;
          be_acc <= '0;
          st     <= S_RECV;
        end
        S_RECV: begin
          if (acc_byte) begin
            cnt <= cnt_next;
            if (flush) begin
              acc    <= '0;
              be_acc <= '0;
            end else begin
              acc    <= merged_word;
              be_acc <= merged_be;
            end
            if (seg_end) begin
              more_q <= !rx_last;
              crc_q  <= rx_last && rx_err;
              st     <= S_WB;
            end
          end
        end
        S_WB: begin
          desc_ptr <= link_q;
          st       <= S_RD_STAT;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         ovr_pend <= 1'b0;
    else if (drop_byte) ovr_pend <= 1'b1;
    else if (wb_fire)   ovr_pend <= 1'b0;
  end

endmodule

// File: rtl/rxd_chk.sv
module rxd_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        rx_ready,
  input logic        mem_req,
  input logic        mem_we,
  input logic [3:0]  mem_be,
  input logic [31:0] mem_wdata,
  input logic        wb_fire,
  input logic        own_stop,
  input logic        fetching,
  input logic        drop_byte,
  input logic        ovr_pend,
  input logic        flush
);
  assert_idle_on_owned_R1: assert property (@(posedge clk) disable iff (!rst_n)
    own_stop |=> (rx_ready && !mem_req));

  assert_partial_be_R3: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> (mem_req && mem_we && mem_be != 4'b0000));

  assert_wb_owner_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wb_fire |-> (mem_we && mem_be == 4'b1111 && mem_wdata[31]));

  assert_frag_not_ok_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_fire && mem_wdata[30]) |-> !mem_wdata[27]);

  assert_drop_marks_R9: assert property (@(posedge clk) disable iff (!rst_n)
    drop_byte |=> ovr_pend);

  assert_ovr_reported_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_fire && ovr_pend) |-> (mem_wdata[25] && !mem_wdata[27]));

  assert_stall_fetch_R11: assert property (@(posedge clk) disable iff (!rst_n)
    fetching |-> !rx_ready);
endmodule

bind rx_ring_dma rxd_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .rx_ready  (rx_ready),
  .mem_req   (mem_req),
  .mem_we    (mem_we),
  .mem_be    (mem_be),
  .mem_wdata (mem_wdata),
  .wb_fire   (wb_fire),
  .own_stop  (own_stop),
  .fetching  (fetching),
  .drop_byte (drop_byte),
  .ovr_pend  (ovr_pend),
  .flush     (flush)
);

// File: tb/sim_rx_ring_dma.sv
module sim_rx_ring_dma;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          rx_enable = 1'b0, base_load = 1'b0;
  logic [AW-1:0] ring_base = '0;
  logic          rx_valid = 1'b0, rx_last = 1'b0, rx_err = 1'b0;
  logic [7:0]    rx_data = '0;
  logic          rx_ready, mem_req, mem_we;
  logic [AW-1:0] mem_addr;
  logic [31:0]   mem_wdata, mem_rdata;
  logic [3:0]    mem_be;

  logic [31:0]   mem [0:255];
  int            n_tests = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_ring_dma #(.AW(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .rx_enable(rx_enable), .base_load(base_load),
    .ring_base(ring_base), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_last(rx_last), .rx_err(rx_err), .rx_ready(rx_ready),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_be(mem_be), .mem_rdata(mem_rdata)
  );

  always @(posedge clk) begin
    if (mem_req && !mem_we) mem_rdata <= mem[mem_addr[7:0]];
    if (mem_req && mem_we) begin
      for (int b = 0; b < 4; b++)
        if (mem_be[b]) mem[mem_addr[7:0]][8*b +: 8] <= mem_wdata[8*b +: 8];
    end
  end

  function automatic logic [31:0] exp_status(input bit more, input bit intr,
      input bit crc, input bit ovr, input int count);
    exp_status = 32'h8000_0000 | (32'(more) << 30) | (32'(intr) << 29)
               | (32'(!more && !crc && !ovr) << 27) | (32'(ovr) << 25)
               | (32'(crc) << 19) | 32'(count & 12'hfff);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic send_byte(input logic [7:0] d, input bit last, input bit err);
    @(negedge clk);
    rx_valid = 1'b1; rx_data = d; rx_last = last; rx_err = err;
    while (!rx_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    rx_valid = 1'b0; rx_last = 1'b0; rx_err = 1'b0;
  endtask

  task automatic send_frame(input int len, input logic [7:0] first, input bit err);
    for (int i = 0; i < len; i++) send_byte(first + 8'(i), i == len - 1, err);
  endtask

  task automatic pulse_enable(input bit load, input logic [AW-1:0] base);
    @(negedge clk);
    rx_enable = 1'b1; base_load = load; ring_base = base;
    @(negedge clk);
    rx_enable = 1'b0; base_load = 1'b0;
  endtask

  task automatic wait_owned(input int addr);
    int t = 0;
    while (!mem[addr][31] && t < 500) begin @(negedge clk); t++; end
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R12 ready after reset", 32'(rx_ready), 32'd1);
    check("R12 no request after reset", 32'(mem_req), 32'd0);
  endtask

  task automatic t_single;
    @(negedge clk);
    rx_enable = 1'b1; base_load = 1'b1; ring_base = 16'd0;
    @(negedge clk);
    rx_enable = 1'b0; base_load = 1'b0;
    check("R11 ready low during fetch", 32'(rx_ready), 32'd0);
    send_frame(10, 8'h10, 1'b0);
    wait_owned(1);
    check("R4 R5 single status", mem[1], exp_status(0, 1, 0, 0, 10));
    check("R2 word 0", mem[64], 32'h1312_1110);
    check("R2 word 1", mem[65], 32'h1716_1514);
    check("R3 partial word", mem[66], 32'hEEEE_1918);
    check("R1 next desc untouched", mem[5], 32'h0000_0020);
  endtask

  task automatic t_crc;
    send_frame(5, 8'h30, 1'b1);
    wait_owned(5);
    check("R7 crc status", mem[5], exp_status(0, 0, 1, 0, 5));
    check("R2 crc data", mem[72], 32'h3332_3130);
    check("R3 crc tail", mem[73], 32'hEEEE_EE34);
  endtask

  task automatic t_frag;
    send_frame(40, 8'h20, 1'b0);
    wait_owned(13);
    check("R6 first fragment", mem[9], exp_status(1, 0, 0, 0, 32));
    check("R6 last fragment", mem[13], exp_status(0, 0, 0, 0, 8));
    check("R6 buffer end", mem[87], 32'h3F3E_3D3C);
    check("R6 continues next buffer", mem[88], 32'h4342_4140);
    check("R6 second word", mem[89], 32'h4746_4544);
    check("R6 no spill", mem[90], 32'hEEEE_EEEE);
  endtask

  task automatic t_idle_drop;
    repeat (10) @(negedge clk);
    check("R1 idle ready", 32'(rx_ready), 32'd1);
    check("R1 idle no request", 32'(mem_req), 32'd0);
    send_frame(6, 8'h90, 1'b0);
    repeat (5) @(negedge clk);
    check("R9 dropped bytes not stored", mem[64], 32'h1312_1110);
    check("R1 R8 owned desc untouched", mem[1], exp_status(0, 1, 0, 0, 10));
    mem[1] = 32'h0000_0020;
    pulse_enable(1'b0, 16'd40);
    send_frame(4, 8'h55, 1'b0);
    wait_owned(1);
    check("R8 R9 R10 resume after wrap with overrun", mem[1], exp_status(0, 0, 0, 1, 4));
    check("R10 resumed buffer", mem[64], 32'h5857_5655);
    check("R1 owned desc1 kept", mem[5], exp_status(0, 0, 1, 0, 5));
  endtask

  task automatic t_base_load;
    repeat (10) @(negedge clk);
    mem[9] = 32'h0000_0020;
    pulse_enable(1'b1, 16'd8);
    send_frame(3, 8'h70, 1'b0);
    wait_owned(9);
    check("R10 R9 base load, overrun cleared", mem[9], exp_status(0, 0, 0, 0, 3));
    check("R3 old byte kept", mem[80], 32'h2372_7170);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 32'hEEEE_EEEE;
    for (int d = 0; d < 4; d++) begin
      mem[4*d]     = 32'((4*d + 4) % 16);
      mem[4*d + 1] = 32'h0000_0020;
      mem[4*d + 2] = 32'(64 + 8*d);
      mem[4*d + 3] = 32'h0;
    end
    mem[1] = 32'h2000_0020;
    t_reset();
    t_single();
    t_crc();
    t_frag();
    t_idle_drop();
    t_base_load();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule